// File: doc/BRIEF.md
# Hybrid Karatsuba GF(2) Polynomial Multiplier

This block takes two 32-bit binary polynomials and returns their full carry-less product, 63 coefficients wide. Bit i of an operand is the coefficient of x^i. Coefficients are added with XOR, so no carry ever moves between bit positions. The product is not reduced; a modular reduction stage placed after this block takes care of that.

The datapath applies two levels of two-way Karatsuba splitting, 32 to 16 bits and then 16 to 8 bits. This leaves nine 8x8 leaf multipliers. Each leaf computes its schoolbook partial products and folds them with a balanced XOR tree, so no row-by-row accumulation takes place. The logic is fully combinational and feeds a single output register. A result therefore appears one clock after its operands are presented together with `in_vld`.

Top module: `gf2_kmul32`

## Requirements
- R1: A synchronous active-high `rst` clears `prod` to zero and `out_vld` to 0 on the next rising clock edge.
- R2: `out_vld` equals the value `in_vld` had at the previous rising clock edge (exactly one cycle of latency).
- R3: When `in_vld` was 1 at an edge, `prod` after that edge equals the carry-less product of the operands sampled at that edge. Bit k of the product is the XOR over all i+j=k of `opa[i]&opb[j]`.
- R4: A zero operand on either side gives a zero product.
- R5: A single-bit operand x^k gives the other operand shifted left by k bit positions.
- R6: When `in_vld` is 0 at an edge, `prod` keeps its previous value, whatever the operand inputs carry.
- R7: Multiplying by an all-ones operand is handled across every bit position, including the top coefficient (bit 62) of the product.
- R8: The product is commutative: swapping `opa` and `opb` gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands are valid this cycle |
| opa | input | 32 | First polynomial, bit i is the coefficient of x^i |
| opb | input | 32 | Second polynomial |
| out_vld | output | 1 | `prod` holds a fresh result |
| prod | output | 63 | Unreduced product, degrees 0..62 |

## Verification
The hardest cases to reach are those where the Karatsuba middle-term correction matters. These need operands whose lower and upper halves overlap at both split levels, so that the sum-operand leaf and the cancellation XORs both carry non-trivial data. Random pairs reach them easily. Directed patterns alone would leave most of the cross terms at zero. The bench therefore combines single-bit walks and all-ones operands with a run of pseudo-random pairs. It compares each result against a bit-serial shift-and-XOR model. It also swaps the operands and holds `in_vld` low while the data inputs change.

// File: rtl/gf2_kmul_pkg.sv
package gf2_kmul_pkg;
  localparam int OP_W   = 32;
  localparam int PROD_W = 2*OP_W - 1;

  // reference carry-less product, used as a spec helper
  function automatic logic [PROD_W-1:0] clmul_ref(input logic [OP_W-1:0] a,
                                                  input logic [OP_W-1:0] b);
    logic [PROD_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < OP_W; i++)
      if (b[i]) acc = acc ^ (PROD_W'(a) << i);
    return acc;
  endfunction
endpackage

// File: rtl/gf2_leaf_mul.sv
// Schoolbook W x W carry-less multiplier. Partial products are folded with a
// balanced XOR tree (pairwise, log2 depth) instead of a linear chain.
module gf2_leaf_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-2:0] p
);
  localparam int PW = 2*W - 1;
  localparam int LV = $clog2(W);
  localparam int NP = 1 << LV;

  logic [PW-1:0] tree [LV+1][NP];

  genvar g, l, n;
  generate
    for (g = 0; g < NP; g++) begin : g_pp
      if (g < W) begin : g_row
        assign tree[0][g] = b[g] ? (PW'(a) << g) : '0;
      end else begin : g_pad
        assign tree[0][g] = '0;
      end
    end
    for (l = 0; l < LV; l++) begin : g_lvl
      for (n = 0; n < NP; n++) begin : g_node
        if (n < (NP >> (l+1))) begin : g_x
          assign tree[l+1][n] = tree[l][2*n] ^ tree[l][2*n+1];
        end else begin : g_z
          assign tree[l+1][n] = '0;
        end
      end
    end
  endgenerate

  assign p = tree[LV][0];
endmodule

// File: rtl/gf2_kara_level.sv
// One two-term Karatsuba level: three sub-products, recursion down to LEAF_W.
module gf2_kara_level #(
  parameter int W      = 32,
  parameter int LEAF_W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-2:0] p
);
  localparam int H  = W / 2;
  localparam int HP = 2*H - 1;
  localparam int PW = 2*W - 1;

  generate
    if (W <= LEAF_W) begin : g_leaf
      gf2_leaf_mul #(.W(W)) u_leaf (.a(a), .b(b), .p(p));
    end else begin : g_split
      logic [H-1:0]  a_lo, a_hi, b_lo, b_hi, a_sum, b_sum;
      logic [HP-1:0] p_lo, p_hi, p_sum, p_mid;
      assign a_lo  = a[H-1:0];
      assign a_hi  = a[W-1:H];
      assign b_lo  = b[H-1:0];
      assign b_hi  = b[W-1:H];
      assign a_sum = a_lo ^ a_hi;
      assign b_sum = b_lo ^ b_hi;

      gf2_kara_level #(.W(H), .LEAF_W(LEAF_W)) u_lo  (.a(a_lo),  .b(b_lo),  .p(p_lo));
      gf2_kara_level #(.W(H), .LEAF_W(LEAF_W)) u_hi  (.a(a_hi),  .b(b_hi),  .p(p_hi));
      gf2_kara_level #(.W(H), .LEAF_W(LEAF_W)) u_sum (.a(a_sum), .b(b_sum), .p(p_sum));

      assign p_mid = p_sum ^ p_lo ^ p_hi;
      assign p = PW'(p_lo) ^ (PW'(p_mid) << H) ^ (PW'(p_hi) << W);
    end
  endgenerate
endmodule

// File: rtl/gf2_kmul32.sv
module gf2_kmul32 #(
  parameter int OP_W   = 32,
  parameter int LEAF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [OP_W-1:0]   opa,
  input  logic [OP_W-1:0]   opb,
  output logic              out_vld,
  output logic [2*OP_W-2:0] prod
);
  localparam int PW = 2*OP_W - 1;

  logic [PW-1:0] comb_prod;
  logic          load_evt;

  gf2_kara_level #(.W(OP_W), .LEAF_W(LEAF_W)) u_core (
    .a(opa), .b(opb), .p(comb_prod)
  );

  assign load_evt = in_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      prod    <= '0;
    end else begin
      out_vld <= in_vld;
      if (load_evt) prod <= comb_prod;
    end
  end
endmodule

// File: rtl/gf2_kmul32_chk.sv
module gf2_kmul32_chk #(
  parameter int OP_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic [OP_W-1:0]   opa,
  input logic [OP_W-1:0]   opb,
  input logic              out_vld,
  input logic [2*OP_W-2:0] prod
);
  logic seen;
  always_ff @(posedge clk) seen <= 1'b1;

  // R1
  reset_clear_chk: assert property (@(posedge clk) seen && rst |=> (!out_vld && prod == '0));
  // R2
  vld_latency_chk: assert property (@(posedge clk) disable iff (rst || !seen) 1'b1 |=> out_vld == $past(in_vld));
  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst || !seen) !in_vld |=> $stable(prod));
  // R4
  zero_op_chk: assert property (@(posedge clk) disable iff (rst || !seen)
                                in_vld && (opa == '0 || opb == '0) |=> prod == '0);
  // R5
  unit_op_chk: assert property (@(posedge clk) disable iff (rst || !seen)
                                in_vld && opb == OP_W'(1) |=> prod == (2*OP_W-1)'($past(opa)));
endmodule

bind gf2_kmul32 gf2_kmul32_chk #(.OP_W(OP_W)) u_chk (.*);

// File: tb/tb_gf2_kmul32.sv
module tb_gf2_kmul32;
  logic clk = 0, rst = 1, in_vld = 0;
  logic [31:0] opa = '0, opb = '0;
  logic out_vld;
  logic [62:0] prod;
  int checks = 0, fails = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  gf2_kmul32 dut (.clk(clk), .rst(rst), .in_vld(in_vld), .opa(opa), .opb(opb),
                  .out_vld(out_vld), .prod(prod));

  // independent bit-serial model: coefficient k = XOR of a[i]&b[k-i]
  function automatic logic [62:0] model(input logic [31:0] a, input logic [31:0] b);
    logic [62:0] r;
    r = '0;
    for (int k = 0; k < 63; k++)
      for (int i = 0; i < 32; i++)
        if (k - i >= 0 && k - i < 32) r[k] = r[k] ^ (a[i] & b[k-i]);
    return r;
  endfunction

  function automatic logic [31:0] rnd(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic chk(input string req, input logic [62:0] act, input logic [62:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // apply one operand pair, sample after the edge
  task automatic mul(input string req, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk); opa = a; opb = b; in_vld = 1;
    @(negedge clk); in_vld = 0;
    chk({req, " vld"}, 63'(out_vld), 63'(1));
    chk(req, prod, model(a, b));
  endtask

  task automatic t_reset;
    rst = 1; in_vld = 1; opa = '1; opb = '1;
    @(negedge clk); @(negedge clk);
    chk("R1 vld", 63'(out_vld), 0);
    chk("R1 prod", prod, 0);
    rst = 0; in_vld = 0;
    @(negedge clk);
    chk("R2 idle", 63'(out_vld), 0);
  endtask

  task automatic t_zero;
    mul("R4 a0", 32'h0, 32'hDEAD_BEEF);
    mul("R4 b0", 32'hCAFE_F00D, 32'h0);
  endtask

  task automatic t_single;
    for (int k = 0; k < 32; k += 5)
      mul("R5", 32'hA5C3_19F7, 32'(1) << k);
    mul("R5 top", 32'h8000_0000, 32'h8000_0000);
  endtask

  task automatic t_ones;
    mul("R7", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R7 bit62", 63'(prod[62]), 63'(1));
  endtask

  task automatic t_random;
    logic [31:0] a, b;
    for (int n = 0; n < 40; n++) begin
      seed = rnd(seed); a = seed; seed = rnd(seed); b = seed ^ {seed[15:0], seed[31:16]};
      mul("R3", a, b);
    end
  endtask

  task automatic t_swap;
    logic [62:0] first;
    mul("R8 ab", 32'h1357_9BDF, 32'h0F1E_2D3C);
    first = prod;
    mul("R8 ba", 32'h0F1E_2D3C, 32'h1357_9BDF);
    chk("R8 equal", prod, first);
  endtask

  task automatic t_hold;
    logic [62:0] keep;
    mul("R6 load", 32'h0BAD_CAFE, 32'h7777_1111);
    keep = prod;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk); opa = 32'hFFFF_0000 + n; opb = 32'h1234 << n; in_vld = 0;
    end
    @(negedge clk);
    chk("R6 hold", prod, keep);
    chk("R2 low", 63'(out_vld), 0);
  endtask

  task automatic t_back2back;
    @(negedge clk); opa = 32'h0000_0F0F; opb = 32'hF0F0_0000; in_vld = 1;
    @(negedge clk);
    chk("R3 b2b1", prod, model(32'h0000_0F0F, 32'hF0F0_0000));
    opa = 32'h9999_9999; opb = 32'h6666_6666;
    @(negedge clk); in_vld = 0;
    chk("R3 b2b2", prod, model(32'h9999_9999, 32'h6666_6666));
    chk("R2 b2b", 63'(out_vld), 1);
  endtask

  initial begin
    fork
      begin
        t_reset; t_zero; t_single; t_ones; t_swap; t_hold; t_back2back; t_random;
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule